// File: doc/BRIEF.md
# Timer Channel with Output Compare and Edge-Aligned PWM

This block is one channel of a general-purpose timer together with the up-counter that drives it. The counter starts each period at a programmable start value and climbs to a programmable top value. It then reloads the start value on the next clock. The channel compares the count with its own threshold register and acts on the pin in one of two ways. In output-compare mode it toggles, clears or sets the pin when the count equals the threshold. In edge-aligned PWM mode every pulse begins at the period start, and the pulse width is the threshold minus the start value.

Software programs the block through a simple write port. Five word addresses hold the top value, the start value, the threshold, a control byte and a flag-clear strobe. A match in either mode sets a sticky flag, and the flag can raise an interrupt. When the two edge/level bits are both zero, the flag and the interrupt still work but the timer releases the pin. The `ch_drive` output reports whether the timer is driving the pin.

Top module: `tmr_channel`

## Requirements
- R1: After reset the count, pin, drive, flag and interrupt are all 0, and all registers are 0. The count rises by one per clock and, in the clock after it reaches or passes the top value, reloads the start value.
- R2: A write with `wr_en` high updates one register, and the new value acts from the next clock. The addresses are 0 for the top value, 1 for the start value, 2 for the threshold, 3 for the control byte and 4 for the flag clear. Control bits: [1:0] edge/level (bit 1 high half, bit 0 low half), [2] mode-B, [3] mode-A, [4] combine, [5] dual-edge, [6] center-aligned, [7] interrupt enable.
- R3: PWM mode is selected only when control bits 6, 5 and 4 are all 0 and bit 2 is 1. Output compare is selected when bits 6, 5, 4 and 2 are 0 and bit 3 is 1. Every other setting leaves the flag unset and the pin undriven.
- R4: In PWM mode with edge/level 2'b10, the pin is high exactly while the count is below the threshold. Each period lasts top minus start plus one clocks, and the pin is high for threshold minus start clocks of it.
- R5: In PWM mode with edge/level bit 0 set, the pin is the inverse of R4: low while the count is below the threshold and high otherwise.
- R6: A threshold at or below the start value gives 0% duty (the pin stays inactive). A threshold above the top value gives 100% duty (the pin stays active).
- R7: In output-compare mode (start value 0), the clock that follows a count equal to the threshold toggles, clears or sets the pin for edge/level 2'b01, 2'b10 and 2'b11. At all other times the pin holds.
- R8: With edge/level 2'b00, `ch_drive` and `ch_out` stay 0, while matches still set the flag.
- R9: In PWM or output-compare mode, the flag becomes 1 in the clock after the count equals the threshold, and it stays 1 until it is cleared.
- R10: Writing 1 to bit 0 at address 4 clears the flag from the next clock. A match in the same clock wins, and the flag stays 1.
- R11: `irq` is high exactly when the flag is 1 and control bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Current counter value |
| ch_out | output | 1 | Channel pin level (0 when not driven) |
| ch_drive | output | 1 | 1 when the timer drives the channel pin |
| chan_flag | output | 1 | Sticky channel match flag |
| irq | output | 1 | Channel interrupt request |

## Verification
The assertions check, on every clock, the counter's step and reload, the flag's set, hold and clear behaviour, and that an output-compare pin moves only on a match. They cannot show the quantities that span a whole period: pulse width, period length, inverted polarity and the 0% and 100% limits. The bench's scenarios show these by counting pin cycles over one period. The scenarios also cover the clear colliding with a match, a released pin that still sets the flag, and the control settings that select neither mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_TOP   = 3'd0;
  localparam logic [ADDR_W-1:0] A_START = 3'd1;
  localparam logic [ADDR_W-1:0] A_THR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd4;

  // Control byte, MSB first
  typedef struct packed {
    logic       irq_en;
    logic       center;
    logic       dual_edge;
    logic       combine;
    logic       mode_a;
    logic       mode_b;
    logic [1:0] edge_lvl;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_OC   = 2'd1,
    CH_PWM  = 2'd2
  } ch_mode_e;

  function automatic ch_mode_e decode_mode(input ctrl_t c);
    logic plain;
    plain = !c.center && !c.dual_edge && !c.combine;
    if (plain && c.mode_b)       return CH_PWM;
    else if (plain && c.mode_a)  return CH_OC;
    else                         return CH_IDLE;
  endfunction

  // Pin after an output-compare match
  function automatic logic oc_action(input logic pin, input logic [1:0] el);
    case (el)
      2'b01:   return !pin;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return pin;
    endcase
  endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic [CW-1:0]     top_q,
  output logic [CW-1:0]     start_q,
  output logic [CW-1:0]     thr_q,
  output ctrl_t             ctrl_q,
  output logic              flag_clr
);

  logic hit_top, hit_start, hit_thr, hit_ctrl;

  assign hit_top   = wr_en && (wr_addr == A_TOP);
  assign hit_start = wr_en && (wr_addr == A_START);
  assign hit_thr   = wr_en && (wr_addr == A_THR);
  assign hit_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign flag_clr  = wr_en && (wr_addr == A_CLR) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q   <= '0;
      start_q <= '0;
      thr_q   <= '0;
      ctrl_q  <= '0;
    end else begin
      if (hit_top)   top_q   <= wr_data;
      if (hit_start) start_q <= wr_data;
      if (hit_thr)   thr_q   <= wr_data;
      if (hit_ctrl)  ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] top,
  input  logic [CW-1:0] start,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic wrap;

  function automatic logic at_top(input logic [CW-1:0] c, input logic [CW-1:0] t);
    return c >= t;
  endfunction

  assign wrap    = at_top(cnt, top);
  assign cnt_nxt = wrap ? start : (cnt + ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // R1
  wrap_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == $past(start));

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> cnt == $past(cnt) + ONE);

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] thr,
  input  ctrl_t         ctrl,
  input  logic          flag_clr,
  output logic          ch_out,
  output logic          ch_drive,
  output logic          flag_q,
  output logic          irq
);

  ch_mode_e mode;
  logic     match_evt;
  logic     pin_q;

  function automatic logic pwm_level(input logic [CW-1:0] c,
                                     input logic [CW-1:0] t,
                                     input logic          low_true);
    return (c < t) ^ low_true;
  endfunction

  assign mode      = decode_mode(ctrl);
  assign match_evt = (mode != CH_IDLE) && (cnt == thr);
  assign ch_drive  = (mode != CH_IDLE) && (ctrl.edge_lvl != 2'b00);
  assign ch_out    = ch_drive && pin_q;
  assign irq       = flag_q && ctrl.irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else begin
      case (mode)
        CH_PWM:  pin_q <= pwm_level(cnt_nxt, thr, ctrl.edge_lvl[0]);
        CH_OC:   if (match_evt) pin_q <= oc_action(pin_q, ctrl.edge_lvl);
        default: pin_q <= pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (match_evt) flag_q <= 1'b1;
    else if (flag_clr)  flag_q <= 1'b0;
  end

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag_q);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !match_evt) |=> !flag_q);

  // R7
  oc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_OC && !match_evt) |=> $stable(pin_q));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              ch_out,
  output logic              ch_drive,
  output logic              chan_flag,
  output logic              irq
);

  logic [CNT_W-1:0] top_q, start_q, thr_q, cnt_nxt;
  ctrl_t            ctrl_q;
  logic             flag_clr;

  tmr_regs #(.CW(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .top_q(top_q), .start_q(start_q), .thr_q(thr_q),
    .ctrl_q(ctrl_q), .flag_clr(flag_clr)
  );

  tmr_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .top(top_q), .start(start_q),
    .cnt(count), .cnt_nxt(cnt_nxt)
  );

  tmr_chan #(.CW(CNT_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .cnt(count), .cnt_nxt(cnt_nxt), .thr(thr_q),
    .ctrl(ctrl_q), .flag_clr(flag_clr), .ch_out(ch_out), .ch_drive(ch_drive),
    .flag_q(chan_flag), .irq(irq)
  );

endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count;
  logic         ch_out, ch_drive, chan_flag, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = !clk;

  tmr_channel #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .ch_out(ch_out), .ch_drive(ch_drive),
    .chan_flag(chan_flag), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference model from the requirements
  logic [W-1:0] m_top = '0, m_start = '0, m_thr = '0, m_cnt = '0;
  logic [7:0]   m_ctrl = '0;
  logic         m_pin = 1'b0, m_flag = 1'b0;

  function automatic int model_mode(input logic [7:0] c);
    if (c[6:4] != 3'b000) return 0;
    if (c[2])             return 2;
    if (c[3])             return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_top <= '0; m_start <= '0; m_thr <= '0; m_ctrl <= '0;
      m_cnt <= '0; m_pin <= 1'b0; m_flag <= 1'b0;
    end else begin : step
      logic [W-1:0] nc;
      int  md;
      bit  hit, clr;
      md  = model_mode(m_ctrl);
      nc  = (m_cnt >= m_top) ? m_start : m_cnt + 1'b1;
      hit = (md != 0) && (m_cnt == m_thr);
      clr = wr_en && (wr_addr == 3'd4) && wr_data[0];
      if (md == 2)
        m_pin <= (nc < m_thr) ? !m_ctrl[0] : m_ctrl[0];
      else if (md == 1 && hit) begin
        if (m_ctrl[1:0] == 2'b01)      m_pin <= !m_pin;
        else if (m_ctrl[1:0] == 2'b10) m_pin <= 1'b0;
        else if (m_ctrl[1:0] == 2'b11) m_pin <= 1'b1;
      end
      m_flag <= hit ? 1'b1 : (clr ? 1'b0 : m_flag);
      m_cnt  <= nc;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_top   <= wr_data;
          3'd1: m_start <= wr_data;
          3'd2: m_thr   <= wr_data;
          3'd3: m_ctrl  <= wr_data[7:0];
          default: ;
        endcase
      end
    end
  end

  // Scoreboard
  typedef struct {
    logic [W-1:0] cnt;
    logic         pin, drv, flg, irq;
    string        pin_tag;
  } exp_t;

  exp_t sb_q[$];

  always @(negedge clk) begin
    if (rst_n) begin : push
      exp_t e;
      int md;
      md        = model_mode(m_ctrl);
      e.cnt     = m_cnt;
      e.drv     = (md != 0) && (m_ctrl[1:0] != 2'b00);
      e.pin     = e.drv && m_pin;
      e.flg     = m_flag;
      e.irq     = m_flag && m_ctrl[7];
      e.pin_tag = (md == 2) ? (m_ctrl[0] ? "R5" : "R4") : (md == 1 ? "R7" : "R3");
      sb_q.push_back(e);
    end
  end

  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin : pop
      exp_t e;
      e = sb_q.pop_front();
      check(count == e.cnt, "R1", "count", int'(count), int'(e.cnt));
      check(ch_out == e.pin, e.pin_tag, "ch_out", int'(ch_out), int'(e.pin));
      check(ch_drive == e.drv, "R8", "ch_drive", int'(ch_drive), int'(e.drv));
      check(chan_flag == e.flg, "R9", "chan_flag", int'(chan_flag), int'(e.flg));
      check(irq == e.irq, "R11", "irq", int'(irq), int'(e.irq));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Count high cycles of ch_out over n clocks
  task automatic high_cycles(input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      #2;
      if (ch_out) hi++;
    end
  endtask

  task automatic wait_count(input logic [W-1:0] v);
    do begin
      @(negedge clk);
      #2;
    end while (count != v);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int hi;
    logic prev;
    idle(3);
    #2 rst_n = 1'b1;
    @(negedge clk); #2;
    // R1 reset state
    check(count == 0 && ch_out == 0 && ch_drive == 0 && chan_flag == 0 && irq == 0,
          "R1", "reset outputs", int'({count[3:0], ch_out, ch_drive, chan_flag, irq}), 0);

    // R2 R4: top 9, start 2, threshold 6, high-true, irq on
    wr(3'd0, 16'd9); wr(3'd1, 16'd2); wr(3'd2, 16'd6); wr(3'd3, 16'h0086);
    idle(14);
    high_cycles(8, hi);
    check(hi == 4, "R4", "high clocks per period", hi, 4);
    check(ch_drive == 1'b1, "R2", "drive after ctrl write", int'(ch_drive), 1);

    // R5: low-true, threshold 4 -> 6 high clocks of 8
    wr(3'd2, 16'd4); wr(3'd3, 16'h0087);
    idle(10);
    high_cycles(8, hi);
    check(hi == 6, "R5", "inverted high clocks", hi, 6);

    // R6: 0% at threshold == start and below, 100% above top
    wr(3'd3, 16'h0086); wr(3'd2, 16'd2);
    idle(10); high_cycles(8, hi);
    check(hi == 0, "R6", "duty at threshold=start", hi, 0);
    wr(3'd2, 16'd1);
    idle(10); high_cycles(8, hi);
    check(hi == 0, "R6", "duty below start", hi, 0);
    wr(3'd2, 16'd12);
    idle(10); high_cycles(8, hi);
    check(hi == 8, "R6", "duty above top", hi, 8);

    // R10: clear away from a match, then clear colliding with a match
    wr(3'd2, 16'd6);
    idle(10);
    check(chan_flag == 1'b1, "R9", "flag after match", int'(chan_flag), 1);
    check(irq == 1'b1, "R11", "irq with enable", int'(irq), 1);
    wait_count(16'd8);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'd1;
    @(negedge clk); wr_en = 1'b0; #2;
    check(chan_flag == 1'b0, "R10", "flag after clear", int'(chan_flag), 0);
    wait_count(16'd6);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'd1;
    @(negedge clk); wr_en = 1'b0; #2;
    check(chan_flag == 1'b1, "R10", "match beats clear", int'(chan_flag), 1);

    // R11: enable off masks irq
    wr(3'd3, 16'h0006);
    idle(2);
    check(irq == 1'b0 && chan_flag == 1'b1, "R11", "irq masked", int'(irq), 0);

    // R8: edge/level 00 releases pin, flag still sets
    wr(3'd3, 16'h0084); wr(3'd4, 16'd1);
    idle(12);
    check(ch_drive == 1'b0 && ch_out == 1'b0, "R8", "pin released", int'(ch_drive), 0);
    check(chan_flag == 1'b1, "R8", "flag with pin released", int'(chan_flag), 1);

    // R3: combine set selects neither mode
    wr(3'd3, 16'h0096); wr(3'd4, 16'd1);
    idle(20);
    check(chan_flag == 1'b0, "R3", "no flag outside modes", int'(chan_flag), 0);
    check(ch_drive == 1'b0, "R3", "no drive outside modes", int'(ch_drive), 0);

    // R7: output compare, start 0, top 7, threshold 3
    wr(3'd1, 16'd0); wr(3'd0, 16'd7); wr(3'd2, 16'd3); wr(3'd3, 16'h0009);
    wait_count(16'd3);
    prev = ch_out;
    @(negedge clk); #2;
    check(ch_out == !prev, "R7", "toggle on match", int'(ch_out), int'(!prev));
    wait_count(16'd3); prev = ch_out;
    @(negedge clk); #2;
    check(ch_out == !prev, "R7", "second toggle", int'(ch_out), int'(!prev));
    wr(3'd3, 16'h000B);
    wait_count(16'd4);
    check(ch_out == 1'b1, "R7", "set on match", int'(ch_out), 1);
    wr(3'd3, 16'h000A);
    wait_count(16'd4);
    check(ch_out == 1'b0, "R7", "clear on match", int'(ch_out), 0);
    idle(3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule